// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

A single-clock on-chip SRAM with a 36-bit word split into four 9-bit byte lanes. Every access has a fixed latency. A command (address, direction, byte enables and selects) is registered on a rising edge, and its data phase falls on the second enabled rising edge after that. For a write, the write data is sampled on that edge. For a read, the data is driven out just after it. Reads and writes share this latency, so the bus can alternate between them on every cycle with no idle turnaround slot.

A command can also open a four-beat burst. Holding the load/advance control high steps an internal beat counter. The two low address bits then follow either a linear wrap-around order or an XOR (interleaved) order, picked by a mode input. The direction and byte enables of a burst come from the command that loaded it. Other controls:
- A clock enable freezes the whole pipeline.
- Three chip selects gate the start of new operations.
- An asynchronous output enable can force the read driver off at any moment.

Tri-state is modelled with a separate driver-enable output next to the read data bus.

Top module: `zt_sram`

## Requirements
- R1: A read command has its data on `rdata`, with `rdata_oe` high, after the second enabled rising edge that follows the command edge.
- R2: Write data on `wdata` is sampled on the second enabled edge after the write command. Write, read and write commands may follow each other on consecutive cycles with no idle cycle.
- R3: While `clk_en_n` is high, all synchronous inputs are ignored and every register holds, so `rdata` and `rdata_oe` stay unchanged and no write happens.
- R4: A new operation starts only when `ld_n` is low, `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. A read or write given with any select inactive does nothing.
- R5: A deselect command does not cancel operations already in the pipeline. A read issued one cycle before a deselect still returns its data.
- R6: `rdata_oe` is low after the second enabled edge following a write command or a deselect.
- R7: With `burst_ilv` low, each advance (`ld_n` high) sets the two low address bits to (base + beat) mod 4. Beats are 0..3, and the upper bits come from the loaded address.
- R8: With `burst_ilv` high, each advance sets the two low address bits to base XOR beat.
- R9: Lane i is bits [9i+8:9i] of the word. A write updates lane i only when `bw_n[i]` is low in the command cycle.
- R10: `oe_n` high forces `rdata_oe` low at once, without waiting for a clock edge. `oe_n` low lets the pipelined enable through.
- R11: During a burst, the values of `cmd_rd` and `bw_n` given on advance cycles are ignored. Direction and byte enables come from the loading command.
- R12: A read of an address issued one cycle after a write to it returns the written lanes from that write and the old contents of the other lanes.
- R13: Synchronous reset (`rst` high at an edge) empties the pipeline and ends any burst, so `rdata_oe` is low afterwards and a read caught in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new command, high advances the burst |
| cmd_rd | input | 1 | 1 read, 0 write (sampled on load only) |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | 0 linear burst order, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data, sampled in the data phase |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | Read driver enable (tri-state model) |

## Verification
A table sequence runs write, write, read, write, read, read and then a deselect on back-to-back cycles. This separates a correct two-edge latency from one that is off by a cycle, and shows whether a read right after a partial write merges lanes through forwarding or returns stale memory. Bursts start from two different base offsets in both orders, and the two orders give distinct address sequences only for those bases. Conflicting direction and byte enables are driven on advance beats to show they are not re-sampled. Further directed patterns cover the following:
- each select held inactive on its own;
- a write presented while the clock enable is frozen;
- the output enable toggled between edges;
- a reset landing on an in-flight read.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int ZT_LANES  = 4;
  localparam int ZT_LANE_W = 9;
  localparam int ZT_BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } ord_e;

  // low address bits of a burst beat
  function automatic logic [ZT_BEAT_W-1:0] beat_addr(
    input logic [ZT_BEAT_W-1:0] base,
    input logic [ZT_BEAT_W-1:0] beat,
    input ord_e                 ord
  );
    return (ord == ORD_INTERLEAVE) ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/zt_cmd.sv
module zt_cmd
  import zt_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = ZT_LANES,
  parameter int BW    = ZT_BEAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             ld_n,
  input  logic             sel_ok,
  input  logic             cmd_rd,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  input  ord_e             ord,
  output logic             s1_vld,
  output logic             s1_rd,
  output logic [LANES-1:0] s1_be,
  output logic [AW-1:0]    s1_adr
);
  logic          act;
  logic [AW-1:0] base_q;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] beat_nx;

  assign beat_nx = beat_q + BW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      act    <= 1'b0;
      beat_q <= '0;
    end else if (ce) begin
      if (!ld_n) begin
        if (sel_ok) begin
          act    <= 1'b1;
          s1_vld <= 1'b1;
          s1_rd  <= cmd_rd;
          s1_be  <= be;
          s1_adr <= addr;
          base_q <= addr;
          beat_q <= '0;
        end else begin
          act    <= 1'b0;
          s1_vld <= 1'b0;
        end
      end else if (act) begin
        // advance: direction and lanes stay from the load
        beat_q <= beat_nx;
        s1_vld <= 1'b1;
        s1_adr <= {base_q[AW-1:BW], beat_addr(base_q[BW-1:0], beat_nx, ord)};
      end else begin
        s1_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zt_lanes.sv
module zt_lanes
  import zt_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = ZT_LANES,
  parameter int LANE_W = ZT_LANE_W,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 2 ** AW
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [AW-1:0]    wr_adr,
  input  logic [DW-1:0]    wr_dat,
  input  logic [AW-1:0]    rd_adr,
  output logic [DW-1:0]    rd_dat
);
  logic hit;
  assign hit = wr_en && (wr_adr == rd_adr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] ram_q;
    logic [LANE_W-1:0] fwd_d;
    logic              fwd_q;

    always_ff @(posedge clk) begin
      if (ce) begin
        if (wr_en && wr_be[g]) ram[wr_adr] <= wr_dat[g*LANE_W +: LANE_W];
        ram_q <= ram[rd_adr];
        fwd_q <= hit && wr_be[g];
        fwd_d <= wr_dat[g*LANE_W +: LANE_W];
      end
    end

    // same-edge write wins over the read-first RAM output
    assign rd_dat[g*LANE_W +: LANE_W] = fwd_q ? fwd_d : ram_q;
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = ZT_LANES,
  parameter int LANE_W = ZT_LANE_W,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             ld_n,
  input  logic             cmd_rd,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             burst_ilv,
  input  logic             oe_n,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  logic             ce;
  logic             sel_ok;
  logic             s1_vld, s1_rd;
  logic [LANES-1:0] s1_be;
  logic [AW-1:0]    s1_adr;
  logic             s2_vld, s2_rd;
  logic [LANES-1:0] s2_be;
  logic [AW-1:0]    s2_adr;
  logic [DW-1:0]    mrg;
  logic [DW-1:0]    rdata_q;
  logic             oe_q;

  assign ce     = ~clk_en_n;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  zt_cmd #(.AW(AW), .LANES(LANES), .BW(ZT_BEAT_W)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .ld_n   (ld_n),
    .sel_ok (sel_ok),
    .cmd_rd (cmd_rd),
    .be     (~bw_n),
    .addr   (addr),
    .ord    (ord_e'(burst_ilv)),
    .s1_vld (s1_vld),
    .s1_rd  (s1_rd),
    .s1_be  (s1_be),
    .s1_adr (s1_adr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld <= 1'b0;
    end else if (ce) begin
      s2_vld <= s1_vld;
      s2_rd  <= s1_rd;
      s2_be  <= s1_be;
      s2_adr <= s1_adr;
    end
  end

  zt_lanes #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk    (clk),
    .ce     (ce),
    .wr_en  (ce & s2_vld & ~s2_rd),
    .wr_be  (s2_be),
    .wr_adr (s2_adr),
    .wr_dat (wdata),
    .rd_adr (s1_adr),
    .rd_dat (mrg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
    end else if (ce) begin
      oe_q <= s2_vld & s2_rd;
      if (s2_vld & s2_rd) rdata_q <= mrg;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = oe_q & ~oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          ld_n,
  input logic          cmd_rd,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe
);
  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && !oe_n && $past(!clk_en_n, 3) && $past(!clk_en_n, 2) && $past(!clk_en_n, 1)
     && $past(!ld_n && !sel_a_n && sel_b && !sel_c_n && cmd_rd, 3)) |-> rdata_oe); // R1

  AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && $past(!clk_en_n, 3) && $past(!clk_en_n, 2) && $past(!clk_en_n, 1)
     && $past(!ld_n && (sel_a_n || !sel_b || sel_c_n || !cmd_rd), 3)) |-> !rdata_oe); // R6

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && $past(clk_en_n) && $stable(oe_n)) |-> ($stable(rdata) && $stable(rdata_oe))); // R3

  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rdata_oe); // R10

  AST_RESET_OFF: assert property (@(posedge clk)
    $past(rst) |-> !rdata_oe); // R13
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en_n (clk_en_n),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .ld_n     (ld_n),
  .cmd_rd   (cmd_rd),
  .oe_n     (oe_n),
  .rdata    (rdata),
  .rdata_oe (rdata_oe)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int DW = 36;

  localparam logic [2:0] SEL_ON    = 3'b010;
  localparam logic [2:0] SEL_A_OFF = 3'b110;
  localparam logic [2:0] SEL_B_OFF = 3'b000;
  localparam logic [2:0] SEL_C_OFF = 3'b011;

  localparam logic [DW-1:0] D0 = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [DW-1:0] D1 = {9'h1F1, 9'h0E2, 9'h0D3, 9'h0C4};
  localparam logic [DW-1:0] D2 = {9'h055, 9'h066, 9'h077, 9'h088};
  localparam logic [DW-1:0] DM = {9'h101, 9'h066, 9'h103, 9'h088};

  typedef struct packed {
    logic          ld;
    logic [2:0]    sel;
    logic          rd;
    logic [3:0]    bw;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic          eoe;
    logic [DW-1:0] ed;
  } row_t;

  // R2/R12/R5/R6: back-to-back write/read mix, no idle cycles
  localparam row_t TBL [9] = '{
    '{1'b0, SEL_ON,    1'b0, 4'h0,    6'd4, 36'h0, 1'b0, 36'h0},
    '{1'b0, SEL_ON,    1'b0, 4'h0,    6'd5, 36'h0, 1'b0, 36'h0},
    '{1'b0, SEL_ON,    1'b1, 4'hF,    6'd4, D0,    1'b0, 36'h0},
    '{1'b0, SEL_ON,    1'b0, 4'b1010, 6'd4, D1,    1'b0, 36'h0},
    '{1'b0, SEL_ON,    1'b1, 4'hF,    6'd4, 36'h0, 1'b1, D0},
    '{1'b0, SEL_ON,    1'b1, 4'hF,    6'd5, D2,    1'b0, 36'h0},
    '{1'b0, SEL_A_OFF, 1'b1, 4'hF,    6'd0, 36'h0, 1'b1, DM},
    '{1'b0, SEL_A_OFF, 1'b1, 4'hF,    6'd0, 36'h0, 1'b1, D1},
    '{1'b0, SEL_A_OFF, 1'b1, 4'hF,    6'd0, 36'h0, 1'b0, 36'h0}
  };

  logic clk = 1'b0, rst = 1'b1, clk_en_n = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic ld_n = 1'b0, cmd_rd = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [3:0]    bw_n  = 4'hF;
  logic [AW-1:0] addr  = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  zt_sram #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .ld_n(ld_n), .cmd_rd(cmd_rd), .bw_n(bw_n), .addr(addr),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] mk(input int a);
    return {9'(a + 'h40), 9'(a + 'h80), 9'(a + 'hC0), 9'(a)};
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic l, input logic [2:0] s, input logic r,
                     input logic [3:0] b, input logic [AW-1:0] a);
    ld_n = l; {sel_a_n, sel_b, sel_c_n} = s; cmd_rd = r; bw_n = b; addr = a;
  endtask

  task automatic idle();
    put(1'b0, SEL_A_OFF, 1'b1, 4'hF, '0);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] b);
    put(1'b0, SEL_ON, 1'b0, b, a); cyc();
    idle(); cyc();
    wdata = d; cyc();
    wdata = '0;
  endtask

  task automatic rd1(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    put(1'b0, SEL_ON, 1'b1, 4'hF, a); cyc();
    idle(); cyc(); cyc();
    chk({req, " drive"}, DW'(rdata_oe), DW'(1));
    chk(req, rdata, exp);
  endtask

  task automatic brst(input logic [AW-1:0] base, input logic ilv, input string req);
    burst_ilv = ilv;
    for (int j = 0; j < 6; j++) begin
      if (j == 0) put(1'b0, SEL_ON, 1'b1, 4'hF, base);
      else if (j <= 3) put(1'b1, SEL_ON, 1'b0, 4'h0, '0); // R11 ignored on advance
      else idle();
      cyc();
      if (j >= 2) begin
        logic [1:0] b = 2'(j - 2);
        logic [AW-1:0] ea;
        ea = {base[AW-1:2], ilv ? (base[1:0] ^ b) : (base[1:0] + b)};
        chk({req, " beat drive"}, DW'(rdata_oe), DW'(1));
        chk(req, rdata, mk(int'(ea)));
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle();
    cyc(); cyc();
    chk("R13 reset drive off", DW'(rdata_oe), DW'(0));
    rst = 1'b0;

    for (int i = 0; i < 9; i++) begin
      put(TBL[i].ld, TBL[i].sel, TBL[i].rd, TBL[i].bw, TBL[i].a);
      wdata = TBL[i].wd;
      cyc();
      chk("R1/R2/R6 table drive", DW'(rdata_oe), DW'(TBL[i].eoe));
      if (TBL[i].eoe) chk("R2/R5/R12 table data", rdata, TBL[i].ed);
    end
    wdata = '0;

    // R4: each select off alone blocks a read
    put(1'b0, SEL_A_OFF, 1'b1, 4'hF, 6'd5); cyc(); idle(); cyc(); cyc();
    chk("R4 sel_a off", DW'(rdata_oe), DW'(0));
    put(1'b0, SEL_B_OFF, 1'b1, 4'hF, 6'd5); cyc(); idle(); cyc(); cyc();
    chk("R4 sel_b off", DW'(rdata_oe), DW'(0));
    put(1'b0, SEL_C_OFF, 1'b1, 4'hF, 6'd5); cyc(); idle(); cyc(); cyc();
    chk("R4 sel_c off", DW'(rdata_oe), DW'(0));
    put(1'b0, SEL_B_OFF, 1'b0, 4'h0, 6'd5); cyc(); idle(); cyc();
    wdata = '1; cyc(); wdata = '0;
    rd1(6'd5, D1, "R4 deselected write ignored");

    // R9 lane writes
    wr1(6'd20, {4{9'h0AA}}, 4'h0);
    wr1(6'd20, {4{9'h155}}, 4'b0110);
    rd1(6'd20, {9'h155, 9'h0AA, 9'h0AA, 9'h155}, "R9 lanes 0 and 3");

    // R7/R8 bursts
    for (int a = 8; a < 12; a++) wr1(AW'(a), mk(a), 4'h0);
    brst(6'd9,  1'b0, "R7 linear base 1");
    brst(6'd11, 1'b0, "R7 linear base 3");
    brst(6'd9,  1'b1, "R8 interleaved base 1");
    brst(6'd11, 1'b1, "R8 interleaved base 3");
    burst_ilv = 1'b0;

    // R11 burst write keeps lane mask and direction
    for (int a = 12; a < 16; a++) wr1(AW'(a), mk(a), 4'h0);
    for (int j = 0; j < 6; j++) begin
      if (j == 0) put(1'b0, SEL_ON, 1'b0, 4'b1110, 6'd12);
      else if (j <= 3) put(1'b1, SEL_ON, 1'b1, 4'h0, '0);
      else idle();
      wdata = (j >= 2) ? {4{9'(9'h1E0 + j - 2)}} : '0;
      cyc();
      chk("R11 no read drive in write burst", DW'(rdata_oe), DW'(0));
    end
    wdata = '0;
    for (int m = 0; m < 4; m++) begin
      logic [DW-1:0] e;
      e = mk(12 + m);
      e[LW-1:0] = 9'(9'h1E0 + m);
      rd1(AW'(12 + m), e, "R11 burst write lane0 only");
    end

    // R3 clock enable freeze
    put(1'b0, SEL_ON, 1'b1, 4'hF, 6'd5); cyc();
    clk_en_n = 1'b1;
    put(1'b0, SEL_ON, 1'b0, 4'h0, 6'd5); wdata = '1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R3 frozen no data yet", DW'(rdata_oe), DW'(0));
    end
    clk_en_n = 1'b0; idle(); wdata = '0;
    cyc();
    chk("R3 one enabled edge", DW'(rdata_oe), DW'(0));
    cyc();
    chk("R3 data after two enabled edges", rdata, D1);
    chk("R3 drive after two enabled edges", DW'(rdata_oe), DW'(1));
    clk_en_n = 1'b1;
    cyc();
    chk("R3 frozen data held", rdata, D1);
    chk("R3 frozen drive held", DW'(rdata_oe), DW'(1));
    // R10 asynchronous output enable
    oe_n = 1'b1; #1;
    chk("R10 oe_n high forces off", DW'(rdata_oe), DW'(0));
    oe_n = 1'b0; #1;
    chk("R10 oe_n low restores", DW'(rdata_oe), DW'(1));
    clk_en_n = 1'b0;
    cyc(); cyc();
    rd1(6'd5, D1, "R3 frozen write ignored");

    // R13 reset drops an in-flight read
    put(1'b0, SEL_ON, 1'b1, 4'hF, 6'd4); cyc();
    rst = 1'b1; idle(); cyc();
    rst = 1'b0; cyc();
    chk("R13 read dropped", DW'(rdata_oe), DW'(0));
    cyc();
    chk("R13 read dropped later", DW'(rdata_oe), DW'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule